// File: doc/BRIEF.md
# Data-Path Timeout Watchdog

This block times how long an SD host's data engine sits waiting on the card. The data engine reports two conditions on separate lines: it is waiting for read data, or it is waiting while the card signals busy. A strobe marks each card bus clock period. Software writes a 32-bit timeout period, counted in card clock cycles, through a small synchronous register port.

Each time the data engine enters either waiting condition, the counter is loaded with the full period. Each card clock strobe that follows, while the engine is still waiting, counts it down. If the count runs out before the engine leaves the waiting conditions, the block sets a sticky timeout flag and gives a one-cycle pulse, which the data engine uses to abort. If the engine leaves both conditions in time, counting stops quietly.

The flag stays set until software writes a clear. The register port has two addresses. Address 0 holds the period. Address 1 reads the flag in bit 0 and clears it on a write with bit 0 set.

Top module: `dto_watchdog`

## Requirements
- R1: After reset, the period register is 0, `tmo_flag` and `tmo_pulse` are 0, and `rd_data` is 0.
- R2: A cycle with `wr_en`=1 and `wr_addr`=0 stores `wr_data` as the period. `rd_data` is registered and shows, one clock after `rd_addr` is sampled, the period for `rd_addr`=0 or `{31'b0, tmo_flag}` for `rd_addr`=1.
- R3: A rising edge of `st_rdwait` or of `st_busy` (an entry) loads the counter with the period. This includes a direct switch from read-wait to busy, which reloads the counter. A `card_clk_en` in the entry cycle does not count.
- R4: While `st_rdwait` or `st_busy` stays high after an entry, each `card_clk_en` counts down once. With period P≥1, the timeout fires on the P-th counted strobe. With period 0, it fires on the first counted strobe.
- R5: While both `st_rdwait` and `st_busy` are low, `card_clk_en` has no effect. Leaving both states before the timeout stops the count without a timeout, and the next entry starts again from the full period.
- R6: `tmo_flag` is set at the clock edge where the timeout fires. It stays set until a write to address 1 with `wr_data[0]`=1. A timeout in the same cycle as a clear leaves the flag set.
- R7: `tmo_pulse` is high for exactly the one cycle after the firing edge, together with the flag being set. Each entry fires at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_rdwait | input | 1 | Data engine is waiting for read data |
| st_busy | input | 1 | Data engine is waiting on card busy |
| card_clk_en | input | 1 | One-cycle strobe per card bus clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 period, 1 status clear |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address: 0 period, 1 status |
| rd_data | output | 32 | Registered read data |
| tmo_flag | output | 1 | Sticky timeout status |
| tmo_pulse | output | 1 | One-cycle timeout indication |

## Verification
The assertions assume that `card_clk_en` is sampled only on rising clock edges. They also assume that the state lines are ordinary synchronous levels, so a pulse's absence can be tied to the inputs of the previous cycle. The bench drives every input at the falling edge, so each input is stable across the rising edge. Periods stay small so that timeouts complete. Direct read-wait to busy switches, entries that coincide with strobes, and clears that coincide with a timeout are all produced deliberately.

// File: rtl/dto_pkg.sv
package dto_pkg;
  typedef enum logic [0:0] {
    DTO_ADDR_PERIOD = 1'b0,
    DTO_ADDR_STATUS = 1'b1
  } dto_addr_e;
endpackage

// File: rtl/dto_rst_sync.sv
module dto_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dto_regs.sv
module dto_regs
  import dto_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_addr,
  input  logic             flag_i,
  output logic [CNT_W-1:0] period_o,
  output logic             clr_o,
  output logic [CNT_W-1:0] rd_data
);
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] rd_q, rd_d;
  logic             wr_period;

  always_comb begin
    wr_period = wr_en && (dto_addr_e'(wr_addr) == DTO_ADDR_PERIOD);
    clr_o     = wr_en && (dto_addr_e'(wr_addr) == DTO_ADDR_STATUS) && wr_data[0];
    period_d  = wr_period ? wr_data : period_q;
    if (dto_addr_e'(rd_addr) == DTO_ADDR_STATUS) rd_d = {{(CNT_W-1){1'b0}}, flag_i};
    else                                          rd_d = period_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      rd_q     <= '0;
    end else begin
      period_q <= period_d;
      rd_q     <= rd_d;
    end
  end

  assign period_o = period_q;
  assign rd_data  = rd_q;
endmodule

// File: rtl/dto_entry.sv
module dto_entry (
  input  logic clk,
  input  logic rst_n,
  input  logic st_rdwait,
  input  logic st_busy,
  output logic load_o,
  output logic qual_o
);
  logic prev_rw_q, prev_bz_q;

  always_comb begin
    load_o = (st_rdwait && !prev_rw_q) || (st_busy && !prev_bz_q);
    qual_o = st_rdwait || st_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rw_q <= 1'b0;
      prev_bz_q <= 1'b0;
    end else begin
      prev_rw_q <= st_rdwait;
      prev_bz_q <= st_busy;
    end
  end
endmodule

// File: rtl/dto_counter.sv
module dto_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic             load_i,
  input  logic             qual_i,
  input  logic             tick_i,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    fire_o  = 1'b0;
    if (!qual_i) begin
      armed_d = 1'b0;
    end else if (load_i) begin
      cnt_d   = period_i;
      armed_d = 1'b1;
    end else if (armed_q && tick_i) begin
      if (cnt_q <= ONE) begin
        fire_o  = 1'b1;
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/dto_status.sv
module dto_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pulse_o
);
  logic flag_q, flag_d;
  logic pulse_q;

  always_comb begin
    if (fire_i)     flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= fire_i;
    end
  end

  assign flag_o  = flag_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/dto_watchdog.sv
module dto_watchdog #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_rdwait,
  input  logic             st_busy,
  input  logic             card_clk_en,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             tmo_flag,
  output logic             tmo_pulse
);
  logic             rst_ni;
  logic [CNT_W-1:0] period;
  logic             clr, load, qual, fire;

  dto_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  dto_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_ni), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .flag_i(tmo_flag),
    .period_o(period), .clr_o(clr), .rd_data(rd_data)
  );

  dto_entry u_entry (
    .clk(clk), .rst_n(rst_ni), .st_rdwait(st_rdwait), .st_busy(st_busy),
    .load_o(load), .qual_o(qual)
  );

  dto_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .period_i(period), .load_i(load),
    .qual_i(qual), .tick_i(card_clk_en), .fire_o(fire)
  );

  dto_status u_stat (
    .clk(clk), .rst_n(rst_ni), .fire_i(fire), .clr_i(clr),
    .flag_o(tmo_flag), .pulse_o(tmo_pulse)
  );
endmodule

// File: rtl/dto_watchdog_chk.sv
module dto_watchdog_chk (
  input logic clk,
  input logic rst_n,
  input logic st_rdwait,
  input logic st_busy,
  input logic card_clk_en,
  input logic wr_en,
  input logic wr_addr,
  input logic wr_bit0,
  input logic tmo_flag,
  input logic tmo_pulse
);
  logic clr_req;
  assign clr_req = wr_en && wr_addr && wr_bit0;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !tmo_pulse); // R7
  AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |-> tmo_flag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !clr_req) |=> tmo_flag); // R6
  AST_FLAG_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> tmo_pulse); // R6
  AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_rdwait && !st_busy) |=> !tmo_pulse); // R5
  AST_NO_TICK_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !card_clk_en |=> !tmo_pulse); // R4
endmodule

bind dto_watchdog dto_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st_rdwait(st_rdwait), .st_busy(st_busy),
  .card_clk_en(card_clk_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_bit0(wr_data[0]), .tmo_flag(tmo_flag), .tmo_pulse(tmo_pulse)
);

// File: tb/sim_dto_watchdog.sv
`timescale 1ns/1ps
module sim_dto_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_rdwait = 1'b0, st_busy = 1'b0, card_clk_en = 1'b0;
  logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tmo_flag, tmo_pulse;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 1'b0, cmp_on = 1'b0;

  // behavioural reference
  longint m_period, m_cnt, m_rd;
  bit m_armed, m_flag, m_pulse, m_prw, m_pbz;

  always #2.5 clk = ~clk;

  dto_watchdog u0 (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_period = 0; m_cnt = 0; m_rd = 0;
      m_armed = 0; m_flag = 0; m_pulse = 0; m_prw = 0; m_pbz = 0;
    end else begin : step
      bit fire, entry, inq;
      fire  = 0;
      inq   = st_rdwait | st_busy;
      entry = (st_rdwait & ~m_prw) | (st_busy & ~m_pbz);
      m_rd  = rd_addr ? longint'(m_flag) : m_period;
      if (!inq) m_armed = 0;
      else if (entry) begin m_cnt = m_period; m_armed = 1; end
      else if (m_armed && card_clk_en) begin
        if (m_cnt <= 1) begin fire = 1; m_armed = 0; m_cnt = 0; end
        else m_cnt = m_cnt - 1;
      end
      if (fire) m_flag = 1;
      else if (wr_en && wr_addr && wr_data[0]) m_flag = 0;
      m_pulse = fire;
      if (wr_en && !wr_addr) m_period = longint'(wr_data);
      m_prw = st_rdwait; m_pbz = st_busy;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (tmo_pulse) pulses++;
    if (cmp_on) begin
      chk("R6 flag", tmo_flag, m_flag);
      chk("R7 pulse", tmo_pulse, m_pulse);
      chk("R2 rd_data", rd_data, m_rd);
    end
  end

  task automatic drive(input logic r, input logic b, input logic e);
    @(negedge clk);
    st_rdwait = r; st_busy = b; card_clk_en = e; wr_en = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; card_clk_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    chk("R1 flag reset", tmo_flag, 0);
    chk("R1 pulse reset", tmo_pulse, 0);
    chk("R1 rd reset", rd_data, 0);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1'b1;
    idle(1);
    chk("R1 period reset", rd_data, 0);

    // R2 write/read period
    wr(1'b0, 32'd5);
    idle(2);
    chk("R2 readback", rd_data, 5);

    // R4 period 5 in read-wait; strobe in entry cycle ignored (R3)
    p0 = pulses;
    drive(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      drive(1'b1, 1'b0, 1'b1);
      if (i == 4) chk("R4 no fire before fifth tick", tmo_flag, 0);
    end
    drive(1'b1, 1'b0, 1'b0);
    chk("R4 fire on fifth tick", tmo_flag, 1);
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b1);
    idle(2);
    chk("R7 one pulse per entry", pulses - p0, 1);
    rd_addr = 1'b1;
    idle(2);
    chk("R2 status read", rd_data, 1);

    // R6 clear
    wr(1'b1, 32'd0);
    idle(2);
    chk("R6 bit0 zero no clear", tmo_flag, 1);
    wr(1'b1, 32'd1);
    idle(2);
    chk("R6 cleared", tmo_flag, 0);

    // R5 exit early, then full reload
    wr(1'b0, 32'd3);
    p0 = pulses;
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, 1'b1);
    chk("R5 no flag after early exit", tmo_flag, 0);
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    chk("R5 full period after re-entry", tmo_flag, 0);
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    chk("R5 fires on third tick of new entry", tmo_flag, 1);
    idle(2);
    chk("R5 pulse count", pulses - p0, 1);

    // R6 set wins over clear in same cycle; period 0 fires on first tick (R4)
    wr(1'b0, 32'd0);
    drive(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    card_clk_en = 1'b1; wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'd1;
    drive(1'b1, 1'b0, 1'b0);
    chk("R6 set beats clear", tmo_flag, 1);
    idle(2);
    wr(1'b1, 32'd1);
    idle(2);

    // R3 direct read-wait -> busy reloads
    wr(1'b0, 32'd4);
    drive(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b1);
    drive(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    chk("R3 reload on busy switch", tmo_flag, 0);
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    chk("R3 fires after reloaded period", tmo_flag, 1);
    idle(2);

    // random stress compared against model each cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      st_rdwait   = ($urandom % 5) != 0 ? st_rdwait : ~st_rdwait;
      st_busy     = ($urandom % 6) != 0 ? st_busy : ~st_busy;
      card_clk_en = ($urandom % 3) == 0;
      rd_addr     = $urandom % 2;
      wr_en       = ($urandom % 20) == 0;
      wr_addr     = $urandom % 2;
      wr_data     = $urandom % 8;
    end
    idle(3);
    done = 1'b1;
    finish_run();
  end
endmodule